// File: doc/BRIEF.md
# Dual Parallel Neuron MAC Bank

This block forms the hidden-layer pre-activation sums of two small perceptron classifiers that work side by side on one image window. Both classifiers see one coefficient per valid clock, and the two streams run in step. One stream carries signed 35-bit wavelet coefficients. The other carries unsigned 12-bit box-sum coefficients. Each classifier has ten multiply-accumulate lanes. On each accepted coefficient, every lane multiplies it by its own weight for that coefficient position and adds the product to an accumulator. Each accumulator starts from that neuron's bias.

A window holds 150 coefficients. Position m is the order of arrival, which equals row times 25 plus column for a 6 by 25 subband. After the last coefficient, a short drain lets the pipeline empty. A one-cycle done pulse then marks all twenty sums as valid, and the sums stay frozen until the next window begins. Weights and biases are written ahead of time, one entry per clock, through a setup port.

A sequencer controls the window with four states:
- IDLE: after reset.
- RUN: coefficients are being taken.
- DRAIN: the pipeline empties and further coefficients are not accepted.
- HOLD: the sums are frozen.

Its transitions are:
- IDLE or HOLD to RUN on the first valid coefficient.
- RUN to DRAIN on the 150th coefficient, or IDLE or HOLD straight to DRAIN if a window has one coefficient.
- DRAIN to HOLD when the drain count expires, which is also when done fires.
- HOLD to RUN when the next window's first coefficient arrives.

Top module: `dual_mac_bank`

## Requirements
- R1: After reset, done is 0 and every bit of d_sum and h_sum is 0.
- R2: A window is the next 150 clocks with coef_vld high that are accepted. Coefficient m (0..149) is the m-th accepted one. Lane k's sum equals bias(k) plus the sum over m of coef(m) times w(m,k).
- R3: d_coef is a 35-bit two's-complement value. Wavelet lane k's sum is a 63-bit two's-complement value taken modulo 2^63, found at d_sum[k*63 +: 63].
- R4: h_coef is a 12-bit unsigned value. Box lane k's sum is a 45-bit two's-complement value, found at h_sum[k*45 +: 45].
- R5: done is high for exactly one clock. That clock is the one that follows the 5th rising edge after the edge that samples the 150th coefficient.
- R6: Once done has fired, both sum buses hold their values until the next window's first coefficient is sampled. At that edge, each sum becomes its sign-extended bias.
- R7: Asserting coef_vld between the 150th coefficient and the done pulse has no effect on the sums or on the done timing.
- R8: A setup write with wr_en=1 targets one entry:
  - wr_sel=0 selects the wavelet classifier and wr_sel=1 the box classifier.
  - wr_neuron selects lane 0..9.
  - wr_index 0..149 selects weight w(wr_index, lane); wr_index 150 selects the lane's bias.
  - wr_data is a 25-bit two's-complement value.
  - A write with wr_neuron above 9 or wr_index above 150 changes nothing.
- R9: Clocks with coef_vld low in the middle of a window pause it without changing any sum.
- R10: Each of the twenty lanes uses only its own weights and bias. A write to one lane changes no other lane's result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| coef_vld | input | 1 | Coefficient pair valid this clock |
| d_coef | input | 35 | Signed wavelet coefficient |
| h_coef | input | 12 | Unsigned box-sum coefficient |
| wr_en | input | 1 | Setup write strobe |
| wr_sel | input | 1 | Classifier select: 0 wavelet, 1 box |
| wr_neuron | input | 4 | Lane index of the write |
| wr_index | input | 8 | Coefficient position 0..149, or 150 for the bias |
| wr_data | input | 25 | Signed weight or bias value |
| done | output | 1 | One-cycle pulse when all sums are valid |
| d_sum | output | 630 | Ten 63-bit wavelet sums, lane k at bits k*63 |
| h_sum | output | 450 | Ten 45-bit box sums, lane k at bits k*45 |

## Verification
The bench drives windows of coefficients that are all zero, ramped, at the extremes of the signed range, and scrambled. The sum of an all-zero window must be exactly the bias, so a design that mishandled the bias would show it there. Extreme signed values together with full-scale box inputs expose a wrong sign or zero extension and a wrong product width.

Some windows have idle gaps, and some keep coef_vld high during the drain. A design whose counter advanced on idle clocks, or that took drain-time data as the start of a new window, would shift positions or corrupt the sums. The bench records done over six consecutive clocks, so a done that comes one clock early or late, or lasts two clocks, is visible. It also checks that the sums stay frozen in HOLD and turn into the bias on the first clock of a new window.

Setup writes to a lane above 9 or to an index above 150 would land in a real lane or table if the decode truncated or aliased the address. A following window would then give wrong sums.

// File: rtl/mac_bank_pkg.sv
package mac_bank_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_RUN   = 2'd1,
        ST_DRAIN = 2'd2,
        ST_HOLD  = 2'd3
    } mb_state_e;

endpackage

// File: rtl/mac_seq.sv
module mac_seq
    import mac_bank_pkg::*;
#(
    parameter int NC  = 150,
    parameter int LAT = 5,
    parameter int IW  = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          coef_vld,
    output logic          start,
    output logic          adv,
    output logic [IW-1:0] idx,
    output logic          done,
    output mb_state_e     st
);
    localparam int DW = $clog2(LAT + 1);

    mb_state_e     state, nxt;
    logic [IW-1:0] cnt;
    logic [DW-1:0] dcnt;
    logic          last, drain_end;

    // combinational outputs of the sequencer
    always_comb begin
        start     = coef_vld && (state == ST_IDLE || state == ST_HOLD);
        adv       = start || (coef_vld && state == ST_RUN);
        idx       = start ? '0 : cnt;
        last      = adv && (idx == IW'(NC - 1));
        drain_end = (state == ST_DRAIN) && (dcnt == DW'(LAT - 1));
    end

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE, ST_HOLD: begin
                if (last)       nxt = ST_DRAIN;
                else if (start) nxt = ST_RUN;
            end
            ST_RUN:   if (last)      nxt = ST_DRAIN;
            ST_DRAIN: if (drain_end) nxt = ST_HOLD;
            default:  nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt  <= '0;
            dcnt <= '0;
            done <= 1'b0;
        end else begin
            if (start)    cnt <= IW'(1);
            else if (adv) cnt <= cnt + IW'(1);
            if (last)                   dcnt <= '0;
            else if (state == ST_DRAIN) dcnt <= dcnt + DW'(1);
            done <= drain_end;
        end
    end

    assign st = state;

endmodule

// File: rtl/mac_lane.sv
module mac_lane #(
    parameter int CW      = 35,
    parameter bit CSIGNED = 1'b1,
    parameter int WW      = 25,
    parameter int AW      = 63,
    parameter int NC      = 150,
    parameter int IW      = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          adv,
    input  logic [IW-1:0] idx,
    input  logic [CW-1:0] coef,
    input  logic          wr_en,
    input  logic [IW-1:0] wr_idx,
    input  logic [WW-1:0] wr_data,
    output logic [AW-1:0] acc
);
    localparam int PW = CW + 1 + WW;

    logic [WW-1:0] tbl [NC];
    logic [WW-1:0] bias;
    logic [CW:0]   cx, cx_q;
    logic [WW-1:0] w_q;
    logic          v1, v2;
    logic signed [PW-1:0] ca, wa, prod;

    // weight table and bias written from the setup port
    always_ff @(posedge clk) begin
        if (wr_en && wr_idx < IW'(NC)) tbl[wr_idx] <= wr_data;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)                             bias <= '0;
        else if (wr_en && wr_idx == IW'(NC))    bias <= wr_data;
    end

    generate
        if (CSIGNED) begin : g_sext
            assign cx = {coef[CW-1], coef};
        end else begin : g_zext
            assign cx = {1'b0, coef};
        end
    endgenerate

    assign ca = {{(PW-CW-1){cx_q[CW]}}, cx_q};
    assign wa = {{(PW-WW){w_q[WW-1]}}, w_q};

    // stage 1: operand capture, stage 2: product, stage 3: accumulate
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cx_q <= '0;
            w_q  <= '0;
            v1   <= 1'b0;
            v2   <= 1'b0;
            prod <= '0;
            acc  <= '0;
        end else begin
            cx_q <= cx;
            w_q  <= tbl[idx];
            v1   <= adv;
            v2   <= v1;
            prod <= ca * wa;
            if (start)   acc <= {{(AW-WW){bias[WW-1]}}, bias};
            else if (v2) acc <= acc + {{(AW-PW){prod[PW-1]}}, prod};
        end
    end

endmodule

// File: rtl/dual_mac_bank.sv
module dual_mac_bank
    import mac_bank_pkg::*;
#(
    parameter int N_NEUR = 10,
    parameter int N_COEF = 150,
    parameter int D_CW   = 35,
    parameter int H_CW   = 12,
    parameter int W_W    = 25,
    parameter int D_AW   = 63,
    parameter int H_AW   = 45,
    parameter int LAT    = 5,
    parameter int NW     = (N_NEUR > 1) ? $clog2(N_NEUR) : 1,
    parameter int IW     = $clog2(N_COEF + 1)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   coef_vld,
    input  logic [D_CW-1:0]        d_coef,
    input  logic [H_CW-1:0]        h_coef,
    input  logic                   wr_en,
    input  logic                   wr_sel,
    input  logic [NW-1:0]          wr_neuron,
    input  logic [IW-1:0]          wr_index,
    input  logic [W_W-1:0]         wr_data,
    output logic                   done,
    output logic [N_NEUR*D_AW-1:0] d_sum,
    output logic [N_NEUR*H_AW-1:0] h_sum
);
    logic          start, adv;
    logic [IW-1:0] idx;
    mb_state_e     st;

    mac_seq #(.NC(N_COEF), .LAT(LAT), .IW(IW)) u_seq (
        .clk(clk), .rst_n(rst_n), .coef_vld(coef_vld),
        .start(start), .adv(adv), .idx(idx), .done(done), .st(st)
    );

    generate
        for (genvar k = 0; k < N_NEUR; k++) begin : g_lane
            localparam logic [NW-1:0] KID = NW'(k);
            logic we_d, we_h;
            assign we_d = wr_en && !wr_sel && (wr_neuron == KID);
            assign we_h = wr_en &&  wr_sel && (wr_neuron == KID);

            mac_lane #(.CW(D_CW), .CSIGNED(1'b1), .WW(W_W), .AW(D_AW),
                       .NC(N_COEF), .IW(IW)) u_d (
                .clk(clk), .rst_n(rst_n), .start(start), .adv(adv),
                .idx(idx), .coef(d_coef), .wr_en(we_d), .wr_idx(wr_index),
                .wr_data(wr_data), .acc(d_sum[k*D_AW +: D_AW])
            );

            mac_lane #(.CW(H_CW), .CSIGNED(1'b0), .WW(W_W), .AW(H_AW),
                       .NC(N_COEF), .IW(IW)) u_h (
                .clk(clk), .rst_n(rst_n), .start(start), .adv(adv),
                .idx(idx), .coef(h_coef), .wr_en(we_h), .wr_idx(wr_index),
                .wr_data(wr_data), .acc(h_sum[k*H_AW +: H_AW])
            );
        end
    endgenerate

endmodule

// File: rtl/dual_mac_bank_chk.sv
module dual_mac_bank_chk
    import mac_bank_pkg::*;
#(
    parameter int N_COEF = 150,
    parameter int SD     = 630,
    parameter int SH     = 450
) (
    input logic          clk,
    input logic          rst_n,
    input logic          coef_vld,
    input logic          done,
    input mb_state_e     st,
    input logic [SD-1:0] d_sum,
    input logic [SH-1:0] h_sum
);
    localparam int CW = $clog2(N_COEF + 2);
    logic [CW-1:0] wcnt;

    // accepted-coefficient count of the current window
    always_ff @(posedge clk) begin
        if (!rst_n) wcnt <= '0;
        else if (coef_vld && (st == ST_IDLE || st == ST_HOLD)) wcnt <= CW'(1);
        else if (coef_vld && st == ST_RUN) wcnt <= wcnt + CW'(1);
    end

    p_done_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_done_after_drain_r5: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ($past(st) == ST_DRAIN && st == ST_HOLD));

    p_window_len_r2: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (wcnt == CW'(N_COEF)));

    p_hold_stable_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_HOLD && !coef_vld) |=> ($stable(d_sum) && $stable(h_sum)));

    p_drain_no_restart_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_DRAIN) |=> (st == ST_DRAIN || st == ST_HOLD));

endmodule

bind dual_mac_bank dual_mac_bank_chk #(
    .N_COEF(N_COEF), .SD(N_NEUR*D_AW), .SH(N_NEUR*H_AW)
) u_chk (
    .clk(clk), .rst_n(rst_n), .coef_vld(coef_vld), .done(done),
    .st(st), .d_sum(d_sum), .h_sum(h_sum)
);

// File: tb/dual_mac_bank_tb.sv
`timescale 1ns/1ps
module dual_mac_bank_tb;
    localparam int NN = 10;
    localparam int NC = 150;
    // vector entry: [1:0] pattern, [2] idle gaps, [3] coef_vld during drain
    localparam logic [3:0] VEC [6] = '{4'h0, 4'h1, 4'h6, 4'h3, 4'h5, 4'hB};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic coef_vld = 1'b0;
    logic [34:0] d_coef = '0;
    logic [11:0] h_coef = '0;
    logic wr_en = 1'b0, wr_sel = 1'b0;
    logic [3:0] wr_neuron = '0;
    logic [7:0] wr_index = '0;
    logic [24:0] wr_data = '0;
    logic done;
    logic [NN*63-1:0] d_sum;
    logic [NN*45-1:0] h_sum;

    always #2.5 clk = ~clk;

    dual_mac_bank u_dut (
        .clk(clk), .rst_n(rst_n), .coef_vld(coef_vld), .d_coef(d_coef),
        .h_coef(h_coef), .wr_en(wr_en), .wr_sel(wr_sel), .wr_neuron(wr_neuron),
        .wr_index(wr_index), .wr_data(wr_data), .done(done),
        .d_sum(d_sum), .h_sum(h_sum)
    );

    int n_chk = 0, n_fail = 0;
    bit finished = 1'b0;
    logic [24:0] wd [NN][NC+1];
    logic [24:0] wh [NN][NC+1];
    logic [34:0] cd [NC];
    logic [11:0] ch [NC];

    task automatic chk(input bit ok, input string tag,
                       input logic [127:0] act, input logic [127:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [24:0] wgen(input int sel, input int k, input int m);
        logic [31:0] t;
        t = (32'(k + 1) * 32'd40503 * 32'(m + 3)) ^ (sel != 0 ? 32'h00A55A5A : 32'h01234567);
        return t[24:0];
    endfunction

    function automatic logic [62:0] exp_d(input int k);
        logic signed [127:0] s;
        s = {{103{wd[k][NC][24]}}, wd[k][NC]};
        for (int m = 0; m < NC; m++)
            s = s + $signed({{93{cd[m][34]}}, cd[m]}) * $signed({{103{wd[k][m][24]}}, wd[k][m]});
        return s[62:0];
    endfunction

    function automatic logic [44:0] exp_h(input int k);
        logic signed [127:0] s;
        s = {{103{wh[k][NC][24]}}, wh[k][NC]};
        for (int m = 0; m < NC; m++)
            s = s + $signed({116'b0, ch[m]}) * $signed({{103{wh[k][m][24]}}, wh[k][m]});
        return s[44:0];
    endfunction

    task automatic wr(input bit sel, input int n, input int i, input logic [24:0] v);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = sel; wr_neuron = 4'(n); wr_index = 8'(i); wr_data = v;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic fill(input int pat);
        for (int m = 0; m < NC; m++) begin
            logic [63:0] t;
            t = 64'(m) * 64'd2654435761 + 64'd977;
            case (pat)
                0: begin cd[m] = '0; ch[m] = '0; end
                1: begin cd[m] = 35'(m + 1); ch[m] = 12'(m); end
                2: begin cd[m] = (m % 2 == 1) ? 35'h400000000 : 35'h3FFFFFFFF; ch[m] = 12'hFFF; end
                default: begin cd[m] = t[40:6]; ch[m] = t[23:12]; end
            endcase
        end
    endtask

    task automatic compare_sums(input string tag);
        for (int k = 0; k < NN; k++) begin
            chk(d_sum[k*63 +: 63] == exp_d(k), {"R3 wavelet sum ", tag},
                128'(d_sum[k*63 +: 63]), 128'(exp_d(k)));
            chk(h_sum[k*45 +: 45] == exp_h(k), {"R4 box sum ", tag},
                128'(h_sum[k*45 +: 45]), 128'(exp_h(k)));
        end
    endtask

    // R2: one window of NC coefficients; R5 done timing recorded over six clocks
    task automatic run_window(input bit gap, input bit junk, input bit peek, input string tag);
        logic [6:1] seen;
        for (int m = 0; m < NC; m++) begin
            if (gap && (m % 7 == 3)) begin
                @(negedge clk);
                coef_vld = 1'b0; d_coef = 35'h7FFFFFFFF; h_coef = 12'hABC;
            end
            @(negedge clk);
            if (peek && m == 1) begin
                chk(d_sum[62:0] == {{38{wd[0][NC][24]}}, wd[0][NC]}, "R6 wavelet bias load",
                    128'(d_sum[62:0]), 128'({{38{wd[0][NC][24]}}, wd[0][NC]}));
                chk(h_sum[44:0] == {{20{wh[0][NC][24]}}, wh[0][NC]}, "R6 box bias load",
                    128'(h_sum[44:0]), 128'({{20{wh[0][NC][24]}}, wh[0][NC]}));
            end
            coef_vld = 1'b1; d_coef = cd[m]; h_coef = ch[m];
        end
        @(negedge clk);
        coef_vld = junk; d_coef = 35'h155555555; h_coef = 12'h777;
        for (int k = 1; k <= 6; k++) begin
            @(negedge clk);
            coef_vld = (k <= 4) ? junk : 1'b0;
            seen[k] = done;
        end
        chk(seen == 6'b010000, {"R5 done timing ", tag}, 128'(seen), 128'(6'b010000));
        compare_sums(tag);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_fail++;
            $display("FAIL R5 watchdog act=hung exp=done");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        chk(done == 1'b0, "R1 done after reset", 128'(done), 128'(0));
        chk(d_sum == '0, "R1 wavelet sums after reset", 128'(d_sum[62:0]), 128'(0));
        chk(h_sum == '0, "R1 box sums after reset", 128'(h_sum[44:0]), 128'(0));
        rst_n = 1'b1;

        // R8: load every weight and bias
        for (int k = 0; k < NN; k++)
            for (int m = 0; m <= NC; m++) begin
                wd[k][m] = wgen(0, k, m);
                wh[k][m] = wgen(1, k, m);
                wr(1'b0, k, m, wd[k][m]);
                wr(1'b1, k, m, wh[k][m]);
            end

        // table-driven windows (R2, R3, R4, R5, R7, R9)
        for (int v = 0; v < 6; v++) begin
            fill(int'(VEC[v][1:0]));
            run_window(VEC[v][2], VEC[v][3], 1'b0, $sformatf("vec%0d", v));
        end

        // R6: held sums stay after done
        repeat (8) @(negedge clk);
        compare_sums("R6 hold");

        // R6: new window loads bias at its first edge
        fill(1);
        run_window(1'b0, 1'b0, 1'b1, "R6 restart");

        // R8: out-of-range writes ignored; R10 single-lane bias rewrite
        wr(1'b0, 12, 3, 25'h1FFFFFF);
        wr(1'b1, 13, 7, 25'h1555555);
        wr(1'b0, 2, 200, 25'h0AAAAAA);
        wr(1'b1, 0, 151, 25'h1234567);
        wd[3][NC] = 25'h1000000;
        wr(1'b0, 3, NC, wd[3][NC]);
        wh[6][40] = 25'h0FFFFFF;
        wr(1'b1, 6, 40, wh[6][40]);
        fill(3);
        run_window(1'b0, 1'b0, 1'b0, "R8 R10 writes");

        finished = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule